// File: doc/BRIEF.md
# Typed Data Packetizer and Flit Serializer

This block sits between a source module and an on-chip data network. The source offers one parallel data word together with a 2-bit type code, a 2-bit destination port and a 2-bit integer-length field that marks the fixed-point position. The block works out from the type code how many data bytes the word carries. It builds a packet from an 8-bit header, those data bytes and a constant 0xFF tail, stores the packet in a flit FIFO, and sends it out as 8-bit flits with a valid/ready handshake.

A small state machine does the cutting. In state IDLE it offers `in_ready` and waits. Transition IDLE→EMIT happens on an accepted word: the full packet is loaded into a shift register and the flit count is loaded into a counter. In state EMIT one flit is written into the FIFO on each cycle. Transition EMIT→IDLE happens on the cycle that writes the tail. The FIFO decouples this writing from the pace set by the network's `flit_ready`.

Top module: `pktz_top`

## Requirements
- R1: The first flit of every packet is the header: bits 7:6 hold the type code, bits 5:4 the destination port, bits 3:2 the integer-length field, and bits 1:0 are zero.
- R2: Type code 00 (coefficient) yields a 9-flit packet: header, the 7 bytes of `in_data[55:0]`, then the tail.
- R3: Type codes 01 (original) and 10 (compared) yield an 8-flit packet: header, the 6 bytes of `in_data[47:0]`, then the tail.
- R4: Type code 11 (result) yields a 3-flit packet: header, `in_data[7:0]`, then the tail.
- R5: The last flit of every packet is 0xFF.
- R6: Data bytes leave most-significant byte first, and packets leave in the order the words were accepted.
- R7: While `flit_valid` is high and `flit_ready` is low, `flit_valid` stays high and `flit_data` keeps its value on the next cycle. The flits of one packet leave on consecutive cycles while `flit_ready` stays high.
- R8: `in_ready` is high only in IDLE and only while the FIFO has room for a 9-flit packet. A word offered while `in_ready` is low is ignored and produces no flits.
- R9: After reset `flit_valid` is low and `in_ready` is high.
- R10: Input data bits above the type's data length have no effect on the flits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Block accepts the offered word this cycle |
| in_data | input | 56 | Data word, right-aligned |
| in_id | input | 2 | Type code |
| in_port | input | 2 | Destination port |
| in_ilen | input | 2 | Integer-length field |
| flit_valid | output | 1 | A flit is presented |
| flit_ready | input | 1 | Network takes the flit |
| flit_data | output | 8 | Flit |

## Verification
Each of the four type codes is sent with random data whose unused upper bits are non-zero. A wrong length, a wrong byte order or leakage of unused bits then shows up as a mismatch in the flit stream. A long run of random packets under a pseudo-random `flit_ready` pattern checks that stalled flits are held and that packet order survives backpressure. A phase with `flit_ready` held low fills the FIFO past the room threshold. A word offered during that phase must not appear in the stream, which tells the room check apart from a plain full check. A single coefficient packet under constant ready checks that its 9 flits leave without gaps.

// File: rtl/pktz_pkg.sv
package pktz_pkg;
    localparam int FLIT_W  = 8;
    localparam int FIELD_W = 2;
    localparam logic [FLIT_W-1:0] TAIL_FLIT = 8'hFF;

    typedef enum logic [FIELD_W-1:0] {
        TY_COEF = 2'b00,
        TY_ORIG = 2'b01,
        TY_CMP  = 2'b10,
        TY_RES  = 2'b11
    } pkt_type_e;

    typedef enum logic {
        S_IDLE,
        S_EMIT
    } emit_state_e;
endpackage

// File: rtl/pktz_len_decode.sv
module pktz_len_decode
    import pktz_pkg::*;
#(
    parameter int MAX_BYTES = 7,
    parameter int CNT_W     = 4
) (
    input  logic [FIELD_W-1:0] id,
    output logic [CNT_W-1:0]   nbytes,
    output logic [CNT_W-1:0]   nflits
);
    always_comb begin
        unique case (pkt_type_e'(id))
            TY_COEF: nbytes = CNT_W'(MAX_BYTES);
            TY_ORIG: nbytes = CNT_W'(MAX_BYTES - 1);
            TY_CMP:  nbytes = CNT_W'(MAX_BYTES - 1);
            TY_RES:  nbytes = CNT_W'(1);
            default: nbytes = CNT_W'(1);
        endcase
        nflits = nbytes + CNT_W'(2);
    end
endmodule

// File: rtl/pktz_flit_fifo.sv
module pktz_flit_fifo
    import pktz_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [FLIT_W-1:0] push_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [FLIT_W-1:0] rd_data,
    output logic [AW:0]       free
);
    logic [FLIT_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [AW:0]       count;
    logic              pop;

    assign rd_valid = (count != '0);
    assign rd_data  = mem[rptr];
    assign pop      = rd_valid && rd_ready;
    assign free     = (AW+1)'(DEPTH) - count;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            count <= count + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < (AW+1)'(DEPTH) || pop)); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> !(rd_valid && !push && $past(!push))); // R7
endmodule

// File: rtl/pktz_top.sv
module pktz_top
    import pktz_pkg::*;
#(
    parameter int DATA_W     = 56,
    parameter int FIFO_DEPTH = 16,
    localparam int MAX_BYTES = DATA_W / FLIT_W,
    localparam int MAX_FLITS = MAX_BYTES + 2,
    localparam int PKT_W     = MAX_FLITS * FLIT_W,
    localparam int BODY_W    = DATA_W + FLIT_W,
    localparam int SH_W      = $clog2(BODY_W) + 1,
    localparam int CNT_W     = $clog2(MAX_FLITS + 1),
    localparam int AW        = $clog2(FIFO_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [FIELD_W-1:0] in_id,
    input  logic [FIELD_W-1:0] in_port,
    input  logic [FIELD_W-1:0] in_ilen,
    output logic               flit_valid,
    input  logic               flit_ready,
    output logic [FLIT_W-1:0]  flit_data
);
    emit_state_e       state, state_nxt;
    logic [PKT_W-1:0]  pkt_sr;
    logic [CNT_W-1:0]  remaining;
    logic [CNT_W-1:0]  nbytes, nflits;
    logic [AW:0]       fifo_free;
    logic              room, accept, push;
    logic [FLIT_W-1:0] push_data, header;
    logic [SH_W-1:0]   shamt;
    logic [BODY_W-1:0] body;

    pktz_len_decode #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_len (
        .id(in_id), .nbytes(nbytes), .nflits(nflits)
    );

    pktz_flit_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_data),
        .rd_valid(flit_valid), .rd_ready(flit_ready), .rd_data(flit_data),
        .free(fifo_free)
    );

    // Packing: header, right-aligned data moved to the top, then tail.
    assign header = {in_id, in_port, in_ilen, 2'b00};
    assign shamt  = (SH_W'(MAX_BYTES) - SH_W'(nbytes)) << 3;
    assign body   = {in_data, TAIL_FLIT} << shamt;
    assign room   = (fifo_free >= (AW+1)'(MAX_FLITS));
    assign accept = in_valid && in_ready;

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (accept) state_nxt = S_EMIT;
            S_EMIT: if (remaining == CNT_W'(1)) state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        push      = 1'b0;
        push_data = pkt_sr[PKT_W-1 -: FLIT_W];
        unique case (state)
            S_IDLE: in_ready = room;
            S_EMIT: push     = 1'b1;
            default: ;
        endcase
    end

    // Shift register and flit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_sr    <= '0;
            remaining <= '0;
        end else if (accept) begin
            pkt_sr    <= {header, body};
            remaining <= nflits;
        end else if (state == S_EMIT) begin
            pkt_sr    <= pkt_sr << FLIT_W;
            remaining <= remaining - 1'b1;
        end
    end

    AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> push && push_data == {$past(in_id), $past(in_port), $past(in_ilen), 2'b00}); // R1
    AST_TAIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (push && state_nxt == S_IDLE) |-> push_data == TAIL_FLIT); // R5
    AST_FLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && !flit_ready) |=> flit_valid && $stable(flit_data)); // R7
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !in_ready); // R8
endmodule

// File: tb/pktz_top_tb.sv
`timescale 1ns/1ps
module pktz_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [55:0] in_data = '0;
    logic [1:0]  in_id = '0, in_port = '0, in_ilen = '0;
    logic        flit_valid;
    logic        flit_ready = 1'b0;
    logic [7:0]  flit_data;

    int tests = 0, fails = 0;
    logic [7:0] exp_q[$];
    logic rand_mode = 1'b0, ready_force = 1'b1;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    pktz_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_id(in_id), .in_port(in_port), .in_ilen(in_ilen),
        .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flit_ready changes 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        flit_ready = rand_mode ? (lfsr[0] | lfsr[3]) : ready_force;
    end

    // Monitor: compares each handshaken flit with the scoreboard (R1-R6, R10)
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin // R7 hold under stall
                check(flit_valid && flit_data == prev_data, "R7 hold", {23'd0, flit_valid, flit_data}, {24'd1, prev_data});
            end
            if (flit_valid && flit_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected flit", {24'd0, flit_data}, 32'd0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(flit_data == e, "R1-R6 flit stream R10", {24'd0, flit_data}, {24'd0, e});
                end
            end
            prev_stall = flit_valid && !flit_ready;
            prev_data  = flit_data;
        end
    end

    task automatic send(input logic [55:0] d, input logic [1:0] id, input logic [1:0] port, input logic [1:0] ilen);
        int nb;
        nb = (id == 2'b00) ? 7 : (id == 2'b11) ? 1 : 6;
        @(negedge clk);
        in_data = d; in_id = id; in_port = port; in_ilen = ilen; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        exp_q.push_back({id, port, ilen, 2'b00});
        for (int i = nb - 1; i >= 0; i--) exp_q.push_back(d[8*i +: 8]);
        exp_q.push_back(8'hFF);
        @(posedge clk);
        #0.5 in_valid = 1'b0;
    endtask

    function automatic logic [55:0] rnd56();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[55:0];
    endfunction

    task automatic drain();
        for (int i = 0; i < 400 && (exp_q.size() != 0 || flit_valid); i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int run;
        repeat (3) @(negedge clk);
        check(flit_valid == 1'b0, "R9 flit_valid", {31'd0, flit_valid}, 0);
        check(in_ready == 1'b1, "R9 in_ready", {31'd0, in_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R9 in_ready after release", {31'd0, in_ready}, 1);

        // R2 R3 R4 R10: each type, upper bits random and non-zero
        send(56'hA1B2C3D4E5F607, 2'b00, 2'b01, 2'b10);
        send(56'hEE112233445566, 2'b01, 2'b10, 2'b01);
        send(56'h77FEDCBA987654, 2'b10, 2'b11, 2'b11);
        send(56'h5A5A5A5A5A5A3C, 2'b11, 2'b00, 2'b01);
        drain();
        check(exp_q.size() == 0, "R2 R3 R4 all flits seen", exp_q.size(), 0);

        // R7: a 9-flit packet leaves on consecutive cycles
        send(rnd56(), 2'b00, 2'b10, 2'b00);
        while (!flit_valid) @(negedge clk);
        run = 0;
        while (flit_valid && run < 20) begin run++; @(negedge clk); end
        check(run == 9, "R7 consecutive flits", run, 9);

        // R6 R7: random packets under backpressure
        rand_mode = 1'b1;
        for (int k = 0; k < 40; k++) begin
            logic [1:0] id;
            id = 2'($urandom());
            send(rnd56(), id, 2'($urandom()), 2'($urandom()));
        end
        drain();
        rand_mode = 1'b0;
        check(exp_q.size() == 0, "R6 order under backpressure", exp_q.size(), 0);

        // R8: fill beyond room threshold, offered word is ignored
        ready_force = 1'b0;
        repeat (3) @(negedge clk);
        send(rnd56(), 2'b00, 2'b01, 2'b01);
        repeat (12) @(negedge clk);
        check(in_ready == 1'b0, "R8 in_ready low when room below 9", {31'd0, in_ready}, 0);
        in_data = 56'h123456789ABCDE; in_id = 2'b11; in_valid = 1'b1;
        repeat (5) @(negedge clk);
        check(in_ready == 1'b0, "R8 still low while offered", {31'd0, in_ready}, 0);
        in_valid = 1'b0;
        ready_force = 1'b1;
        drain();
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0 && !flit_valid, "R8 ignored word produced no flits", {31'd0, flit_valid}, 0);
        check(in_ready == 1'b1, "R8 in_ready back after drain", {31'd0, in_ready}, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule